// File: doc/BRIEF.md
# Snooping Write-Invalidate Line Coherence Controller

This block keeps a small direct-mapped tag-and-state table for a write-back cache attached to a shared snooping bus. Every line is in one of three states: Invalid (no data), Shared (clean, readable) or Exclusive (the only copy, writable and dirty). Processor reads and writes arrive over a ready/valid request port. The controller answers hits locally and, for misses and upgrades, issues one bus request at a time. It holds that request until the bus grants it.

The controller also watches every transaction other caches place on the bus. When another cache misses on a line held Exclusive here, the controller raises a one-cycle intervention pulse so the data path can supply the dirty block. It then downgrades or drops the line. Invalidates and write misses from other caches remove local copies. Evicting a dirty line first issues a writeback of the victim. A pending upgrade or victim writeback is adjusted when a snoop takes the line before the grant arrives.

The line address is split into a low index of clog2(LINES) bits and a tag made of the remaining upper bits.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, cpu_req_ready_o is 1, and bus_req_valid_o, cpu_resp_valid_o and snoop_wb_o are 0.
- R2: A processor read that misses raises bus_req_valid_o with command 1 (read miss) and the request address. One cycle after the grant, cpu_resp_valid_o pulses with cpu_resp_hit_o=0, and the line is Shared.
- R3: A processor write that misses issues command 2 (write miss). After the grant the line is Exclusive, and later reads and writes to it hit.
- R4: A read to a Shared or Exclusive line, or a write to an Exclusive line, produces cpu_resp_valid_o with cpu_resp_hit_o=1 one cycle after acceptance and causes no bus request.
- R5: A processor write to a Shared line issues command 3 (invalidate) for that address. After the grant the line is Exclusive.
- R6: A snooped read miss (command 1) that matches an Exclusive line raises snoop_wb_o for one cycle, on the cycle after the snoop, with snoop_wb_addr_o equal to the snooped address. The line becomes Shared.
- R7: A snooped write miss (2) or invalidate (3) that matches a valid line makes it Invalid. A write miss that matches an Exclusive line also raises snoop_wb_o.
- R8: A snoop has no effect when it is a read miss on a Shared line, a writeback (command 0), or an address whose tag does not match. In these cases snoop_wb_o stays 0 and the line state is unchanged.
- R9: A miss whose indexed line is Exclusive with another tag first issues command 0 (writeback) with the victim address, then the miss request. A Shared victim is replaced with no writeback.
- R10: cpu_req_ready_o is 0 while a bus transaction for an accepted request is outstanding and in any cycle in which snoop_valid_i is 1.
- R11: If a snooped invalidate or write miss to the same line arrives before an upgrade is granted, the pending command 3 becomes command 2.
- R12: If a snoop takes the victim line out of Exclusive before the writeback is granted, the writeback is dropped and the miss request is issued directly.
- R13: While bus_req_valid_o is 1 and neither a grant nor a snoop occurs, the request address and command stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_valid_i | input | 1 | Processor request valid |
| cpu_req_ready_o | output | 1 | Controller can accept a request |
| cpu_req_write_i | input | 1 | 1 = write, 0 = read |
| cpu_req_addr_i | input | ADDR_W | Processor line address |
| cpu_resp_valid_o | output | 1 | One-cycle completion pulse |
| cpu_resp_hit_o | output | 1 | Completed without any bus transaction |
| bus_req_valid_o | output | 1 | Bus request pending |
| bus_req_cmd_o | output | 2 | 0 writeback, 1 read miss, 2 write miss, 3 invalidate |
| bus_req_addr_o | output | ADDR_W | Bus request line address |
| bus_gnt_i | input | 1 | Grant and completion of the pending request |
| snoop_valid_i | input | 1 | Transaction from another cache seen on the bus |
| snoop_cmd_i | input | 2 | Snooped command, same encoding as bus_req_cmd_o |
| snoop_addr_i | input | ADDR_W | Snooped line address |
| snoop_wb_o | output | 1 | Supply dirty block (intervention) |
| snoop_wb_addr_o | output | ADDR_W | Address of the block to supply |

## Verification
The bench builds the controller with ADDR_W=8 and LINES=4, so the low two address bits select a line. Addresses such as 0x21, 0x31 and 0x41 therefore collide on one line. With these values, replacement of Exclusive and Shared victims and snoops whose tag does not match are reached in a handful of accesses. The bench delays grants to observe held requests. It also places snoops between an upgrade or victim writeback and its grant, which exercises the command conversion and the dropped writeback.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_WB     = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_INV    = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/coh_tag_table.sv
module coh_tag_table
  import coh_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 13,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [TAG_W-1:0] rd_a_tag_o,
  output line_st_e         rd_a_st_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [TAG_W-1:0] rd_b_tag_o,
  output line_st_e         rd_b_st_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  line_st_e         fill_st_i,
  input  logic             snp_en_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  line_st_e         snp_st_i
);
  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= LS_INV;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_en_i && fill_idx_i == IDX_W'(i)) begin
          tag_q[i] <= fill_tag_i;
          st_q[i]  <= fill_st_i;
        end else if (snp_en_i && snp_idx_i == IDX_W'(i)) begin
          st_q[i] <= snp_st_i;
        end
      end
    end
  end

  assign rd_a_tag_o = tag_q[rd_a_idx_i];
  assign rd_a_st_o  = st_q[rd_a_idx_i];
  assign rd_b_tag_o = tag_q[rd_b_idx_i];
  assign rd_b_st_o  = st_q[rd_b_idx_i];

  // bus serializes own fills against foreign snoops
  assert_one_writer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> !snp_en_i);
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_cmd_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  output logic              snp_en_o,
  output line_st_e          snp_st_o,
  output logic              snoop_wb_o,
  output logic [ADDR_W-1:0] snoop_wb_addr_o
);
  logic line_hit, wb_d, wb_q;
  logic [ADDR_W-1:0] wb_addr_q;

  assign line_hit = (line_st_i != LS_INV) &&
                    (line_tag_i == snoop_addr_i[ADDR_W-1:IDX_W]);

  always_comb begin
    snp_en_o = 1'b0;
    snp_st_o = line_st_i;
    wb_d     = 1'b0;
    if (snoop_valid_i && line_hit) begin
      unique case (snoop_cmd_i)
        BC_RDMISS: if (line_st_i == LS_EXC) begin
          snp_en_o = 1'b1;
          snp_st_o = LS_SHR;
          wb_d     = 1'b1;
        end
        BC_WRMISS: begin
          snp_en_o = 1'b1;
          snp_st_o = LS_INV;
          wb_d     = (line_st_i == LS_EXC);
        end
        BC_INV: begin
          snp_en_o = 1'b1;
          snp_st_o = LS_INV;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q      <= 1'b0;
      wb_addr_q <= '0;
    end else begin
      wb_q <= wb_d;
      if (wb_d) wb_addr_q <= snoop_addr_i;
    end
  end

  assign snoop_wb_o      = wb_q;
  assign snoop_wb_addr_o = wb_addr_q;

  assert_wb_needs_snoop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_wb_o |-> $past(snoop_valid_i) && $past(snoop_cmd_i != BC_WB) &&
                   $past(snoop_cmd_i != BC_INV));

  assert_wb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_wb_o && !snoop_valid_i |=> !snoop_wb_o);
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_write_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  output logic              cpu_resp_valid_o,
  output logic              cpu_resp_hit_o,
  output logic              bus_req_valid_o,
  output logic [1:0]        bus_req_cmd_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  input  logic              bus_gnt_i,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_cmd_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic [IDX_W-1:0]  tab_idx_o,
  input  logic [TAG_W-1:0]  tab_tag_i,
  input  line_st_e          tab_st_i,
  output logic              fill_en_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output line_st_e          fill_st_o
);
  typedef enum logic [1:0] {F_IDLE, F_VWB, F_BUS} fsm_e;

  fsm_e              fsm_q;
  logic [ADDR_W-1:0] addr_q;
  bus_cmd_e          cmd_q;
  logic [TAG_W-1:0]  vtag_q;
  logic              resp_q, hit_q;

  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic             accept, req_hit, victim_live, line_killed;

  assign idx_q = addr_q[IDX_W-1:0];
  assign tag_q = addr_q[ADDR_W-1:IDX_W];

  assign cpu_req_ready_o = (fsm_q == F_IDLE) && !snoop_valid_i;
  assign accept          = cpu_req_valid_i && cpu_req_ready_o;
  assign tab_idx_o       = (fsm_q == F_IDLE) ? cpu_req_addr_i[IDX_W-1:0] : idx_q;
  assign req_hit         = (tab_st_i != LS_INV) &&
                           (tab_tag_i == cpu_req_addr_i[ADDR_W-1:IDX_W]);
  assign victim_live     = (tab_st_i == LS_EXC) && (tab_tag_i == vtag_q);
  assign line_killed     = snoop_valid_i && (snoop_addr_i == addr_q) &&
                           (snoop_cmd_i == BC_INV || snoop_cmd_i == BC_WRMISS);

  always_comb begin
    bus_req_valid_o = 1'b0;
    bus_req_cmd_o   = cmd_q;
    bus_req_addr_o  = addr_q;
    if (fsm_q == F_VWB) begin
      bus_req_valid_o = victim_live;
      bus_req_cmd_o   = BC_WB;
      bus_req_addr_o  = {vtag_q, idx_q};
    end else if (fsm_q == F_BUS) begin
      bus_req_valid_o = 1'b1;
    end
  end

  assign fill_en_o  = bus_gnt_i && bus_req_valid_o;
  assign fill_idx_o = idx_q;
  assign fill_tag_o = (fsm_q == F_VWB) ? vtag_q : tag_q;
  assign fill_st_o  = (fsm_q == F_VWB)     ? LS_INV :
                      (cmd_q == BC_RDMISS) ? LS_SHR : LS_EXC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q  <= F_IDLE;
      addr_q <= '0;
      cmd_q  <= BC_RDMISS;
      vtag_q <= '0;
      resp_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      resp_q <= 1'b0;
      hit_q  <= 1'b0;
      unique case (fsm_q)
        F_IDLE: if (accept) begin
          addr_q <= cpu_req_addr_i;
          if (req_hit && (!cpu_req_write_i || tab_st_i == LS_EXC)) begin
            resp_q <= 1'b1;
            hit_q  <= 1'b1;
          end else if (req_hit) begin
            cmd_q <= BC_INV;
            fsm_q <= F_BUS;
          end else begin
            cmd_q <= cpu_req_write_i ? BC_WRMISS : BC_RDMISS;
            if (tab_st_i == LS_EXC) begin
              vtag_q <= tab_tag_i;
              fsm_q  <= F_VWB;
            end else begin
              fsm_q <= F_BUS;
            end
          end
        end
        F_VWB: if (!victim_live || bus_gnt_i) fsm_q <= F_BUS;
        F_BUS: begin
          if (bus_gnt_i) begin
            fsm_q  <= F_IDLE;
            resp_q <= 1'b1;
          end else if (line_killed && cmd_q == BC_INV) begin
            cmd_q <= BC_WRMISS;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign cpu_resp_valid_o = resp_q;
  assign cpu_resp_hit_o   = hit_q;

  assert_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_o |-> !cpu_req_ready_o);

  assert_req_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_o && !bus_gnt_i && !snoop_valid_i |=>
      bus_req_valid_o && $stable(bus_req_addr_o) && $stable(bus_req_cmd_o));

  assert_miss_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_resp_valid_o && !cpu_resp_hit_o |-> $past(bus_gnt_i));

  assert_gnt_needs_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i |-> bus_req_valid_o && !snoop_valid_i);
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_write_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  output logic              cpu_resp_valid_o,
  output logic              cpu_resp_hit_o,
  output logic              bus_req_valid_o,
  output logic [1:0]        bus_req_cmd_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  input  logic              bus_gnt_i,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_cmd_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              snoop_wb_o,
  output logic [ADDR_W-1:0] snoop_wb_addr_o
);
  logic [IDX_W-1:0] a_idx, fill_idx;
  logic [TAG_W-1:0] a_tag, b_tag, fill_tag;
  line_st_e         a_st, b_st, fill_st, snp_st;
  logic             fill_en, snp_en;

  coh_tag_table #(.LINES(LINES), .TAG_W(TAG_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (a_idx),
    .rd_a_tag_o (a_tag),
    .rd_a_st_o  (a_st),
    .rd_b_idx_i (snoop_addr_i[IDX_W-1:0]),
    .rd_b_tag_o (b_tag),
    .rd_b_st_o  (b_st),
    .fill_en_i  (fill_en),
    .fill_idx_i (fill_idx),
    .fill_tag_i (fill_tag),
    .fill_st_i  (fill_st),
    .snp_en_i   (snp_en),
    .snp_idx_i  (snoop_addr_i[IDX_W-1:0]),
    .snp_st_i   (snp_st)
  );

  coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cpu_req_valid_i  (cpu_req_valid_i),
    .cpu_req_ready_o  (cpu_req_ready_o),
    .cpu_req_write_i  (cpu_req_write_i),
    .cpu_req_addr_i   (cpu_req_addr_i),
    .cpu_resp_valid_o (cpu_resp_valid_o),
    .cpu_resp_hit_o   (cpu_resp_hit_o),
    .bus_req_valid_o  (bus_req_valid_o),
    .bus_req_cmd_o    (bus_req_cmd_o),
    .bus_req_addr_o   (bus_req_addr_o),
    .bus_gnt_i        (bus_gnt_i),
    .snoop_valid_i    (snoop_valid_i),
    .snoop_cmd_i      (snoop_cmd_i),
    .snoop_addr_i     (snoop_addr_i),
    .tab_idx_o        (a_idx),
    .tab_tag_i        (a_tag),
    .tab_st_i         (a_st),
    .fill_en_o        (fill_en),
    .fill_idx_o       (fill_idx),
    .fill_tag_o       (fill_tag),
    .fill_st_o        (fill_st)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .snoop_valid_i   (snoop_valid_i),
    .snoop_cmd_i     (snoop_cmd_i),
    .snoop_addr_i    (snoop_addr_i),
    .line_tag_i      (b_tag),
    .line_st_i       (b_st),
    .snp_en_o        (snp_en),
    .snp_st_o        (snp_st),
    .snoop_wb_o      (snoop_wb_o),
    .snoop_wb_addr_o (snoop_wb_addr_o)
  );
endmodule

// File: tb/coh_snoop_ctrl_tb_top.sv
module coh_snoop_ctrl_tb_top;
  localparam int AW = 8;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          gnt = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          cpu_req_ready_o, cpu_resp_valid_o, cpu_resp_hit_o;
  logic          bus_req_valid_o, snoop_wb_o;
  logic [1:0]    bus_req_cmd_o;
  logic [AW-1:0] bus_req_addr_o, snoop_wb_addr_o;

  int total = 0, bad = 0, busy_cnt = 0, cyc = 0;

  always #2 clk = ~clk;

  coh_snoop_ctrl #(.ADDR_W(AW), .LINES(NL)) dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .cpu_req_valid_i  (req_valid),
    .cpu_req_ready_o  (cpu_req_ready_o),
    .cpu_req_write_i  (req_write),
    .cpu_req_addr_i   (req_addr),
    .cpu_resp_valid_o (cpu_resp_valid_o),
    .cpu_resp_hit_o   (cpu_resp_hit_o),
    .bus_req_valid_o  (bus_req_valid_o),
    .bus_req_cmd_o    (bus_req_cmd_o),
    .bus_req_addr_o   (bus_req_addr_o),
    .bus_gnt_i        (gnt),
    .snoop_valid_i    (snp_valid),
    .snoop_cmd_i      (snp_cmd),
    .snoop_addr_i     (snp_addr),
    .snoop_wb_o       (snoop_wb_o),
    .snoop_wb_addr_o  (snoop_wb_addr_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (bus_req_valid_o) busy_cnt++;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cpu_req(input logic w, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    while (!cpu_req_ready_o) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic bus_serve(input string r, input logic [1:0] cmd, input logic [AW-1:0] a,
                           input int dly);
    @(negedge clk);
    while (!bus_req_valid_o) @(negedge clk);
    chk(r, bus_req_cmd_o, cmd);
    chk(r, bus_req_addr_o, a);
    chk("R10 stall", cpu_req_ready_o, 0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R13 hold", {bus_req_valid_o, bus_req_cmd_o, bus_req_addr_o}, {1'b1, cmd, a});
    end
    gnt = 1'b1;
    @(posedge clk);
    #1 gnt = 1'b0;
  endtask

  task automatic wait_resp(input string r, input logic exp_hit);
    @(negedge clk);
    chk(r, cpu_resp_valid_o, 1);
    chk(r, cpu_resp_hit_o, exp_hit);
  endtask

  task automatic hit_access(input string r, input logic w, input logic [AW-1:0] a);
    int b;
    b = busy_cnt;
    cpu_req(w, a);
    wait_resp(r, 1'b1);
    chk(r, busy_cnt - b, 0);
  endtask

  task automatic miss_access(input string r, input logic w, input logic [AW-1:0] a,
                             input logic [1:0] cmd);
    cpu_req(w, a);
    bus_serve(r, cmd, a, 0);
    wait_resp(r, 1'b0);
  endtask

  task automatic snoop(input string r, input logic [1:0] cmd, input logic [AW-1:0] a,
                       input logic exp_wb);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #1 chk("R10 snoop stall", cpu_req_ready_o, 0);
    @(posedge clk);
    #1 snp_valid = 1'b0;
    @(negedge clk);
    chk(r, snoop_wb_o, exp_wb);
    if (exp_wb) chk(r, snoop_wb_addr_o, a);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ready", cpu_req_ready_o, 1);
    chk("R1 bus", bus_req_valid_o, 0);
    chk("R1 resp", cpu_resp_valid_o, 0);
    chk("R1 wb", snoop_wb_o, 0);
  endtask

  task automatic t_read_path;
    cpu_req(1'b0, 8'h10);
    bus_serve("R2 read miss", 2'd1, 8'h10, 3);
    wait_resp("R2 resp", 1'b0);
    hit_access("R4 shared read", 1'b0, 8'h10);
    miss_access("R5 upgrade", 1'b1, 8'h10, 2'd3);
    hit_access("R4 excl write", 1'b1, 8'h10);
  endtask

  task automatic t_write_miss;
    miss_access("R3 write miss", 1'b1, 8'h21, 2'd2);
    hit_access("R3 read after", 1'b0, 8'h21);
    hit_access("R3 write after", 1'b1, 8'h21);
  endtask

  task automatic t_intervention;
    snoop("R6 rdmiss on excl", 2'd1, 8'h21, 1'b1);
    miss_access("R6 now shared", 1'b1, 8'h21, 2'd3);
    snoop("R6 rdmiss on excl b", 2'd1, 8'h10, 1'b1);
    snoop("R8 rdmiss on shared", 2'd1, 8'h10, 1'b0);
    hit_access("R8 still valid", 1'b0, 8'h10);
    snoop("R8 wb cmd", 2'd0, 8'h10, 1'b0);
    snoop("R8 tag mismatch", 2'd2, 8'h30, 1'b0);
    hit_access("R8 unchanged", 1'b0, 8'h10);
  endtask

  task automatic t_invalidate;
    snoop("R7 wrmiss on excl", 2'd2, 8'h21, 1'b1);
    miss_access("R7 line gone", 1'b0, 8'h21, 2'd1);
    snoop("R7 inv on shared", 2'd3, 8'h10, 1'b0);
    miss_access("R7 line gone b", 1'b0, 8'h10, 2'd1);
  endtask

  task automatic t_replace;
    miss_access("R5 upgrade b", 1'b1, 8'h21, 2'd3);
    cpu_req(1'b0, 8'h31);
    bus_serve("R9 victim wb", 2'd0, 8'h21, 0);
    bus_serve("R9 then miss", 2'd1, 8'h31, 0);
    wait_resp("R9 resp", 1'b0);
    snoop("R9 victim dropped", 2'd1, 8'h21, 1'b0);
    miss_access("R9 shared victim", 1'b0, 8'h41, 2'd1);
  endtask

  task automatic t_upgrade_race;
    miss_access("R2 read miss c", 1'b0, 8'h52, 2'd1);
    cpu_req(1'b1, 8'h52);
    @(negedge clk);
    chk("R5 inv pending", {bus_req_valid_o, bus_req_cmd_o}, {1'b1, 2'd3});
    snoop("R11 foreign inv", 2'd3, 8'h52, 1'b0);
    bus_serve("R11 converted", 2'd2, 8'h52, 0);
    wait_resp("R11 resp", 1'b0);
    hit_access("R11 excl read", 1'b0, 8'h52);
    hit_access("R11 excl write", 1'b1, 8'h52);
  endtask

  task automatic t_victim_race;
    miss_access("R3 write miss b", 1'b1, 8'h13, 2'd2);
    cpu_req(1'b0, 8'h23);
    @(negedge clk);
    chk("R9 wb pending", {bus_req_valid_o, bus_req_cmd_o, bus_req_addr_o},
        {1'b1, 2'd0, 8'h13});
    snoop("R12 victim taken", 2'd2, 8'h13, 1'b1);
    bus_serve("R12 wb dropped", 2'd1, 8'h23, 0);
    wait_resp("R12 resp", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_read_path();
    t_write_miss();
    t_intervention();
    t_invalidate();
    t_replace();
    t_upgrade_race();
    t_victim_race();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule